// File: doc/BRIEF.md
# PCI Interrupt Link Router

This block steers eight shared, level-sensitive interrupt link pins onto a bus of sixteen legacy IRQ lines. Each link pin owns a routing register. The register holds a disable flag and a four-bit target IRQ number, and a small register port reads and writes it. Devices signal a request on a link with a one-cycle raise strobe and withdraw it with a one-cycle drop strobe. The block counts the requesters outstanding on each pin, so that a pin shared by several devices stays asserted until the last one has dropped.

Each IRQ output is high while at least one pin is active, is validly routed and targets that line. Only a fixed set of IRQ numbers may be used as targets. A pin whose register selects any other number is handled as if it were disabled. A request on a pin that is not validly routed appears on that pin's fallback output instead of on the IRQ bus. Rewriting a register while its pin is active moves the asserted level from the old line to the new line at a single clock edge.

Top module: `irq_link_router`

## Requirements
- R1: After reset every routing register reads 0x80, every requester count is zero, and `irq_out`, `fallback_out` and `underflow_err` are all low.
- R2: A write with `reg_addr` 1 to 8 updates the register of pin `reg_addr`-1 at the next clock edge and stores only bits 7 and 3:0 of `reg_wdata`. Bits 6:4 are stored as zero. A write to address 0 or 9 to 15 changes no register. `reg_rdata` shows the addressed register combinationally and shows 0 for an address outside 1 to 8.
- R3: A register is valid only when bit 7 (disable) is clear and bits 3:0 select an IRQ in the allowed set {3,4,5,6,7,9,10,11,12,14,15}, which is the mask 0xDEF8. An invalid register never drives any `irq_out` line.
- R4: A raise strobe increments the pin's count at the next edge. While the count is nonzero and the register is valid, `irq_out[bits 3:0]` is high.
- R5: A drop strobe decrements the count. The routed line stays high until the count has returned to zero.
- R6: The four-bit count saturates at 15, and a raise strobe at 15 is ignored.
- R7: A drop strobe at count zero leaves the count at zero and raises `underflow_err` for exactly the following cycle.
- R8: A raise strobe and a drop strobe on the same pin in the same cycle leave the count unchanged.
- R9: Writing a different value to a pin with a nonzero count moves the asserted level from the old line to the new line at one edge. Writing the value already stored has no visible effect.
- R10: `fallback_out[p]` is high exactly while pin p has a nonzero count and an invalid register.
- R11: Several active pins may share one IRQ line. The line is the OR of those pins and stays high while any one of them is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address; link pins are 1 to 8 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read of the addressed register |
| req_raise | input | 8 | Per-pin request raise strobes |
| req_drop | input | 8 | Per-pin request drop strobes |
| irq_out | output | 16 | Legacy IRQ lines |
| fallback_out | output | 8 | Per-pin fallback request, active when the pin is not validly routed |
| underflow_err | output | 1 | High for the cycle after a drop strobe hit a zero count |

## Verification
Two functions can fall on the same clock edge: a register rewrite and a count change on the same pin. The bench drives a write together with a raise strobe to a pin that is idle, and a rewrite together with balanced raise and drop strobes to a pin that is active. The expected line after that edge comes from the new register value and the updated count together. A second case sends a raise strobe and a drop strobe to the same pin in the same cycle, and the bench judges that the line level and the underflow flag do not change.

// File: rtl/irq_link_pkg.sv
package irq_link_pkg;
    localparam int          LINK_CNT  = 8;
    localparam int          IRQ_LINES = 16;
    localparam int          REG_W     = 8;
    localparam int          SEL_W     = 4;
    localparam int          CNT_W     = 4;
    localparam int          DIS_BIT   = 7;
    localparam logic [15:0] ALLOWED   = 16'hDEF8;
    localparam logic [7:0]  KEEP_MASK = 8'h8F;
    localparam logic [7:0]  RESET_VAL = 8'h80;

    typedef struct packed {
        logic [REG_W-1:0] route;
        logic [CNT_W-1:0] cnt;
        logic             uflow;
    } slot_state_t;

    function automatic logic route_ok(input logic [REG_W-1:0] r);
        return !r[DIS_BIT] && ALLOWED[r[SEL_W-1:0]];
    endfunction
endpackage

// File: rtl/irq_link_slot.sv
module irq_link_slot
    import irq_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             ev_up,
    input  logic             ev_down,
    output logic [REG_W-1:0] route_o,
    output logic             active_o,
    output logic             valid_o,
    output logic             uflow_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    slot_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.uflow = 1'b0;
        if (wr_hit) begin
            s_d.route = wdata & KEEP_MASK;
        end
        unique case ({ev_up, ev_down})
            2'b10: if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
            2'b01: begin
                if (s_q.cnt == '0) s_d.uflow = 1'b1;
                else               s_d.cnt   = s_q.cnt - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.route <= RESET_VAL;
            s_q.cnt   <= '0;
            s_q.uflow <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign route_o  = s_q.route;
    assign active_o = (s_q.cnt != '0);
    assign valid_o  = route_ok(s_q.route);
    assign uflow_o  = s_q.uflow;

    assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> route_o == ($past(wdata) & KEEP_MASK));
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && ev_up && !ev_down) |=> s_q.cnt == CNT_MAX);
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && ev_down && !ev_up) |=> (uflow_o && !active_o));
    assert_balanced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_up && ev_down) |=> $stable(s_q.cnt));
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
    import irq_link_pkg::*;
#(
    parameter int LINKS = LINK_CNT,
    parameter int LINES = IRQ_LINES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LINKS-1:0][SEL_W-1:0] sel,
    input  logic [LINKS-1:0]            active,
    input  logic [LINKS-1:0]            valid,
    output logic [LINES-1:0]            irq_o,
    output logic [LINKS-1:0]            fb_o
);
    always_comb begin
        irq_o = '0;
        for (int p = 0; p < LINKS; p++) begin
            if (active[p] && valid[p]) irq_o[sel[p]] = 1'b1;
        end
    end

    for (genvar p = 0; p < LINKS; p++) begin : g_fb
        assign fb_o[p] = active[p] && !valid[p];
    end

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (irq_o == '0 && fb_o == '0));
    assert_reserved_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~ALLOWED) == '0);
endmodule

// File: rtl/irq_link_router.sv
module irq_link_router
    import irq_link_pkg::*;
#(
    parameter int LINKS  = LINK_CNT,
    parameter int LINES  = IRQ_LINES,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [LINKS-1:0]  req_raise,
    input  logic [LINKS-1:0]  req_drop,
    output logic [LINES-1:0]  irq_out,
    output logic [LINKS-1:0]  fallback_out,
    output logic              underflow_err
);
    logic [LINKS-1:0][REG_W-1:0] route;
    logic [LINKS-1:0][SEL_W-1:0] sel;
    logic [LINKS-1:0]            hit, active, valid, uflow;

    for (genvar p = 0; p < LINKS; p++) begin : g_slot
        assign hit[p] = reg_wr_en && (reg_addr == ADDR_W'(p + 1));
        assign sel[p] = route[p][SEL_W-1:0];
        irq_link_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit[p]),
            .wdata   (reg_wdata),
            .ev_up   (req_raise[p]),
            .ev_down (req_drop[p]),
            .route_o (route[p]),
            .active_o(active[p]),
            .valid_o (valid[p]),
            .uflow_o (uflow[p])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < LINKS; p++) begin
            if (reg_addr == ADDR_W'(p + 1)) reg_rdata = route[p];
        end
    end

    irq_line_merge #(.LINKS(LINKS), .LINES(LINES)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .active(active),
        .valid (valid),
        .irq_o (irq_out),
        .fb_o  (fallback_out)
    );

    assign underflow_err = |uflow;

    assert_fallback_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fallback_out & ~active) == '0);
    assert_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (reg_addr == '0 || reg_addr > ADDR_W'(LINKS))) |=> $stable(route));
endmodule

// File: tb/irq_link_router_tb_top.sv
`timescale 1ns/1ps
module irq_link_router_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] req_raise = '0, req_drop = '0;
    logic [15:0] irq_out;
    logic [7:0] fallback_out;
    logic       underflow_err;

    always #2.5 clk = ~clk;

    irq_link_router dut_i (.*);

    typedef struct {
        logic [15:0] irq;
        logic [7:0]  fb;
        logic        err;
        logic [7:0]  rd;
        string       tag;
    } exp_t;
    exp_t q[$];

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_route[8];
    int m_cnt[8];

    function automatic bit ok(int r);
        return (r[7] == 1'b0) && ((16'hDEF8 >> (r & 15)) & 1);
    endfunction

    task automatic step(bit wr, int addr, int wd, logic [7:0] up, logic [7:0] dn, string tag);
        exp_t e;
        @(negedge clk);
        reg_wr_en = wr; reg_addr = 4'(addr); reg_wdata = 8'(wd);
        req_raise = up; req_drop = dn;
        e.err = 0;
        for (int p = 0; p < 8; p++) begin
            if (up[p] && !dn[p] && m_cnt[p] < 15) m_cnt[p]++;
            else if (dn[p] && !up[p]) begin
                if (m_cnt[p] == 0) e.err = 1; else m_cnt[p]--;
            end
        end
        if (wr && addr >= 1 && addr <= 8) m_route[addr-1] = wd & 8'h8F;
        e.irq = '0; e.fb = '0;
        for (int p = 0; p < 8; p++) begin
            if (m_cnt[p] != 0 && ok(m_route[p])) e.irq[m_route[p] & 15] = 1'b1;
            if (m_cnt[p] != 0 && !ok(m_route[p])) e.fb[p] = 1'b1;
        end
        e.rd = (addr >= 1 && addr <= 8) ? 8'(m_route[addr-1]) : 8'h00;
        e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (irq_out !== e.irq || fallback_out !== e.fb ||
                    underflow_err !== e.err || reg_rdata !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: irq=%h fb=%h err=%b rd=%h expected irq=%h fb=%h err=%b rd=%h",
                             e.tag, irq_out, fallback_out, underflow_err, reg_rdata,
                             e.irq, e.fb, e.err, e.rd);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        for (int p = 0; p < 8; p++) begin m_route[p] = 8'h80; m_cnt[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(0, 1, 0, 8'h00, 8'h00, "R1 reset pin1");
        step(0, 8, 0, 8'h00, 8'h00, "R1 reset pin8");
        // R2: masking, stray addresses
        step(1, 1, 8'hF5, 8'h00, 8'h00, "R2 mask keeps bit7");
        step(1, 1, 8'h75, 8'h00, 8'h00, "R2 mask drops 6:4");
        step(1, 0, 8'h03, 8'h00, 8'h00, "R2 addr0 read zero");
        step(1, 9, 8'h03, 8'h00, 8'h00, "R2 addr9 ignored");
        step(0, 1, 0, 8'h00, 8'h00, "R2 pin1 unchanged");
        // R4/R5: counting on pin1 -> IRQ5
        step(0, 1, 0, 8'h01, 8'h00, "R4 raise pin1");
        step(0, 1, 0, 8'h01, 8'h00, "R5 second requester");
        step(0, 1, 0, 8'h00, 8'h01, "R5 one drop holds");
        step(0, 1, 0, 8'h00, 8'h01, "R5 last drop clears");
        // R7: underflow
        step(0, 1, 0, 8'h00, 8'h01, "R7 underflow flagged");
        step(0, 1, 0, 8'h00, 8'h00, "R7 flag one cycle");
        // R3/R10: reserved targets
        step(1, 2, 8'h08, 8'h00, 8'h00, "R3 route reserved 8");
        step(0, 2, 0, 8'h02, 8'h00, "R10 fallback reserved");
        step(1, 2, 8'h02, 8'h00, 8'h00, "R3 reserved 2");
        step(1, 2, 8'h0D, 8'h00, 8'h00, "R3 reserved 13");
        step(1, 2, 8'h0E, 8'h00, 8'h00, "R3 allowed 14 moves");
        step(0, 2, 0, 8'h00, 8'h02, "R4 drop pin2");
        // R11: shared line
        step(1, 3, 8'h05, 8'h05, 8'h00, "R11 two pins on IRQ5");
        step(0, 3, 0, 8'h00, 8'h01, "R11 line held by pin3");
        // R9: re-steer
        step(1, 3, 8'h0B, 8'h00, 8'h00, "R9 move to IRQ11");
        step(1, 3, 8'h0B, 8'h00, 8'h00, "R9 identical write");
        step(1, 3, 8'h8B, 8'h00, 8'h00, "R9 disable to fallback");
        step(1, 3, 8'h0C, 8'h00, 8'h00, "R9 re-enable IRQ12");
        // R8: same-cycle functions
        step(1, 4, 8'h06, 8'h08, 8'h00, "R8 write+raise pin4");
        step(1, 3, 8'h07, 8'h04, 8'h04, "R8 rewrite+balanced pin3");
        step(0, 1, 0, 8'h01, 8'h01, "R8 balanced at zero");
        step(0, 3, 0, 8'h00, 8'h0C, "R5 drop pins 3 4");
        // R6: saturation on pin5 -> IRQ3
        step(1, 5, 8'h03, 8'h00, 8'h00, "R6 route pin5");
        for (int i = 0; i < 20; i++) step(0, 5, 0, 8'h10, 8'h00, "R6 raise pin5");
        for (int i = 0; i < 15; i++) step(0, 5, 0, 8'h00, 8'h10, "R6 drop pin5");
        step(0, 5, 0, 8'h00, 8'h10, "R7 underflow after saturation");
        step(0, 5, 0, 8'h00, 8'h00, "R1 quiet end");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule